// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block reads one page of a raw NAND flash device over its multiplexed I/O bus. A single start pulse carries a block index, a page index, a starting column and a number of data cycles. The block first waits until the flash reports ready. It then sends the read-setup command, the two column and three row address bytes, and the read-confirm command. After that it waits out the array-load busy time and clocks out the requested number of words on read-enable pulses. Each word is handed to the consumer on a one-cycle valid strobe.

Every interface time is a parameter counted in clock cycles: write and read low time, high time, the delay before busy is sampled, the ready-to-read gap and the busy timeout. A slow clock and a fast clock can therefore both meet the flash's nanosecond minimums. Chip enable stays low from the first command until the last data word, so devices that abort a read when deselected are served. The ready/busy input is resynchronized before use. A busy period longer than the timeout ends the operation with an error pulse. The bus can be 8 or 16 bits wide. On a 16-bit bus, commands and addresses travel on the low byte and the upper byte is driven to zero.

Top module: `nand_rdseq`

## Requirements
- R1: During and straight after reset, chip enable, write enable and read enable are high (inactive), command latch and address latch are low, the I/O output enable is low and `busy_o` is low.
- R2: Each accepted start produces exactly seven write cycles in this order: command byte 0x00 with the command latch high; five bytes with the address latch high, namely col[7:0], col[11:8] zero-extended, row[7:0], row[15:8], row[23:16], where row = {block, page} zero-extended; then command byte 0x30 with the command latch high.
- R3: Every write-enable low pulse lasts exactly T_WP cycles. I/O data, command latch and address latch do not change while write enable is low or on the cycle it rises. Command latch and address latch are never high together.
- R4: Write enable never falls while the ready/busy input is low. A start given while the flash is busy issues no write cycle until ready returns.
- R5: Chip enable stays low without a break from the first write cycle of an operation until its completion or error strobe, including the whole busy period.
- R6: The first read-enable fall comes T_RR+3 clock cycles after ready/busy rises: two synchronizer stages, one cycle for the sequencer to see ready, then T_RR gap cycles.
- R7: The I/O output enable is high throughout every write-enable low pulse and low throughout every read-enable low pulse.
- R8: Exactly count_i read-enable pulses are issued, each low for T_WP cycles. The bus is sampled on the clock edge that ends the low phase. The word appears on `rd_data_o` with `rd_valid_o` high for one cycle on the next cycle. A count of zero issues no read pulse.
- R9: After the last data word, `done_o` pulses for one cycle with chip enable already high, and `busy_o` is low on the following cycle.
- R10: If ready/busy stays low for T_TMO cycles in the busy wait, `err_o` pulses for one cycle with chip enable high, no `done_o` and no data strobe occur, and the block returns to idle.
- R11: A start pulse while `busy_o` is high is ignored: the running operation still issues exactly seven write cycles and a single completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| block_i | input | BLK_W | Block index |
| page_i | input | PAGE_W | Page index within block |
| col_i | input | COL_W | First column (byte or word) |
| count_i | input | CNT_W | Number of data cycles |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | One-cycle busy-timeout strobe |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_o | output | DW | I/O bus value driven out |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_i | input | DW | I/O bus value read in |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| rd_data_o | output | DW | Read data word |
| rd_valid_o | output | 1 | Read data valid strobe |

## Verification
Each write slot lasts T_WP+T_WH cycles. The bench latches each command or address byte on the rising write-enable edge, where the flash would, and then compares the seven bytes with values built from the start inputs. Read data is due one cycle after the edge that ends a read-enable low phase. The bench flash model changes its bus word only after that edge, and the bench compares `rd_data_o` on the falling clock edge while the strobe is high. Ready-to-read spacing is counted in falling edges from the ready rise, and the bench expects the first read-enable low at exactly T_RR+3. The busy timeout must occur between T_TMO and T_TMO+T_WB+8 cycles after busy is held.

// File: rtl/nand_rdseq_pkg.sv
package nand_rdseq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_WRDY, ST_CMD1, ST_ADDR, ST_CMD2,
      ST_WB, ST_BUSY, ST_RR, ST_READ, ST_DONE, ST_ERR
   } rdseq_state_e;
   localparam logic [7:0] CMD_SETUP   = 8'h00;
   localparam logic [7:0] CMD_CONFIRM = 8'h30;
   localparam int         N_ADDR      = 5;
endpackage

// File: rtl/nand_rdseq_sync.sv
module nand_rdseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nand_rdseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_rdseq_fmt.sv
module nand_rdseq_fmt #(
   parameter int DW    = 8,
   parameter int COL_W = 12,
   parameter int ROW_W = 17
) (
   input  logic             is_cmd_i,
   input  logic [7:0]       cmd_i,
   input  logic [2:0]       idx_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [ROW_W-1:0] row_i,
   output logic [DW-1:0]    io_o
);
   logic [15:0] col_x;
   logic [23:0] row_x;
   logic [7:0]  byte_sel;

   assign col_x = 16'(col_i);
   assign row_x = 24'(row_i);

   always_comb begin
      if (is_cmd_i) byte_sel = cmd_i;
      else begin
         case (idx_i)
            3'd0:    byte_sel = col_x[7:0];
            3'd1:    byte_sel = col_x[15:8];
            3'd2:    byte_sel = row_x[7:0];
            3'd3:    byte_sel = row_x[15:8];
            default: byte_sel = row_x[23:16];
         endcase
      end
   end

   if (DW == 8) begin : g_x8
      assign io_o = byte_sel;
   end else begin : g_x16
      assign io_o = {{(DW-8){1'b0}}, byte_sel};
   end
endmodule

// File: rtl/nand_rdseq.sv
module nand_rdseq
   import nand_rdseq_pkg::*;
#(
   parameter int DW       = 8,
   parameter int COL_W    = 12,
   parameter int PAGE_W   = 6,
   parameter int BLK_W    = 11,
   parameter int CNT_W    = 12,
   parameter int T_WP     = 2,
   parameter int T_WH     = 2,
   parameter int T_WB     = 4,
   parameter int T_RR     = 2,
   parameter int T_TMO    = 200,
   parameter int SYNC_STG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BLK_W-1:0]  block_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DW-1:0]     nand_io_o,
   output logic              nand_io_oe,
   input  logic [DW-1:0]     nand_io_i,
   input  logic              nand_rb_n,
   output logic [DW-1:0]     rd_data_o,
   output logic              rd_valid_o
);
   localparam int ROW_W = BLK_W + PAGE_W;
   localparam int SLOT  = T_WP + T_WH;
   localparam int TW    = $clog2(SLOT + T_WB + T_RR + 1);
   localparam int OW    = $clog2(T_TMO + 1);

   if (!(DW == 8 || DW == 16)) begin : g_bad_dw
      $error("nand_rdseq: DW must be 8 or 16");
   end
   if (ROW_W > 24 || COL_W > 16) begin : g_bad_addr
      $error("nand_rdseq: row must fit 24 bits and column 16 bits");
   end
   if (T_WP < 1 || T_WH < 1 || T_WB < 1 || T_RR < 1 || T_TMO < 2) begin : g_bad_time
      $error("nand_rdseq: timing parameters out of range");
   end

   rdseq_state_e     state_q;
   logic [TW-1:0]    tmr_q;
   logic [OW-1:0]    tmo_q;
   logic [2:0]       aidx_q;
   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] left_q;
   logic             rb_s;
   logic             slot_end, wr_phase, low_phase;

   nand_rdseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rb_sync (
      .clk(clk), .rst_n(rst_n), .d_i(nand_rb_n), .q_o(rb_s)
   );

   nand_rdseq_fmt #(.DW(DW), .COL_W(COL_W), .ROW_W(ROW_W)) u_fmt (
      .is_cmd_i (state_q != ST_ADDR),
      .cmd_i    ((state_q == ST_CMD2) ? CMD_CONFIRM : CMD_SETUP),
      .idx_i    (aidx_q),
      .col_i    (col_q),
      .row_i    (row_q),
      .io_o     (nand_io_o)
   );

   assign slot_end  = (tmr_q == TW'(SLOT - 1));
   assign low_phase = (tmr_q < TW'(T_WP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         tmr_q      <= '0;
         tmo_q      <= '0;
         aidx_q     <= '0;
         col_q      <= '0;
         row_q      <= '0;
         left_q     <= '0;
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               col_q   <= col_i;
               row_q   <= {block_i, page_i};
               left_q  <= count_i;
               tmo_q   <= '0;
               state_q <= ST_WRDY;
            end
            ST_WRDY, ST_BUSY: begin
               if (rb_s) begin
                  tmr_q   <= '0;
                  state_q <= (state_q == ST_WRDY) ? ST_CMD1 : ST_RR;
               end else if (tmo_q == OW'(T_TMO - 1)) state_q <= ST_ERR;
               else tmo_q <= tmo_q + 1'b1;
            end
            ST_CMD1: begin
               tmr_q <= slot_end ? '0 : tmr_q + 1'b1;
               if (slot_end) begin
                  aidx_q  <= '0;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               tmr_q <= slot_end ? '0 : tmr_q + 1'b1;
               if (slot_end) begin
                  if (aidx_q == 3'(N_ADDR - 1)) state_q <= ST_CMD2;
                  else aidx_q <= aidx_q + 1'b1;
               end
            end
            ST_CMD2: begin
               tmr_q <= slot_end ? '0 : tmr_q + 1'b1;
               if (slot_end) state_q <= ST_WB;
            end
            ST_WB: begin
               tmr_q <= tmr_q + 1'b1;
               if (tmr_q == TW'(T_WB - 1)) begin
                  tmo_q   <= '0;
                  state_q <= ST_BUSY;
               end
            end
            ST_RR: begin
               tmr_q <= tmr_q + 1'b1;
               if (tmr_q == TW'(T_RR - 1)) begin
                  tmr_q   <= '0;
                  state_q <= (left_q == '0) ? ST_DONE : ST_READ;
               end
            end
            ST_READ: begin
               tmr_q <= slot_end ? '0 : tmr_q + 1'b1;
               if (tmr_q == TW'(T_WP - 1)) begin
                  rd_data_o  <= nand_io_i;
                  rd_valid_o <= 1'b1;
                  left_q     <= left_q - 1'b1;
               end
               if (slot_end && left_q == '0) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_phase   = (state_q == ST_CMD1) || (state_q == ST_ADDR) || (state_q == ST_CMD2);
      nand_cle   = (state_q == ST_CMD1) || (state_q == ST_CMD2);
      nand_ale   = (state_q == ST_ADDR);
      nand_we_n  = !(wr_phase && low_phase);
      nand_re_n  = !((state_q == ST_READ) && low_phase);
      nand_io_oe = wr_phase;
      nand_ce_n  = (state_q == ST_IDLE) || (state_q == ST_WRDY) ||
                   (state_q == ST_DONE) || (state_q == ST_ERR);
      busy_o     = (state_q != ST_IDLE);
      done_o     = (state_q == ST_DONE);
      err_o      = (state_q == ST_ERR);
   end

   // R3: latch strobes exclusive, bus steady across the write pulse
   a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   a_r3_steady_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> ($stable(nand_io_o) && $stable(nand_cle) && $stable(nand_ale)));
   // R4: no write cycle while synchronized ready/busy reports busy
   a_r4_no_we_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_s |-> nand_we_n);
   // R7: bus released whenever read enable is low
   a_r7_oe_off_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_io_oe);
   // R8: a data strobe always follows a read-enable low cycle
   a_r8_valid_after_re: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(!nand_re_n));
   // R5 / R9 / R10: chip enable is released only at completion or error
   a_r5_ce_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_ce_n) |-> (done_o || err_o));
   // R10: error and completion never coincide
   a_r10_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
endmodule

// File: tb/nand_rdseq_tb_top.sv
module nand_rdseq_tb_top;
   localparam int T_WP = 2, T_RR = 2, T_WB = 4, T_TMO = 200;

   typedef struct packed {
      logic [10:0] blk;
      logic [5:0]  pg;
      logic [11:0] col;
      logic [11:0] n;
      logic [15:0] bsy;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{11'h001, 6'h00, 12'h000, 12'd4, 16'd20},
      '{11'h7FF, 6'h3F, 12'h800, 12'd3, 16'd8},
      '{11'h2A5, 6'h15, 12'hFFF, 12'd1, 16'd40},
      '{11'h155, 6'h2A, 12'h123, 12'd6, 16'd5},
      '{11'h0F0, 6'h01, 12'h07E, 12'd0, 16'd12}
   };

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [10:0] block_i = '0;
   logic [5:0]  page_i = '0;
   logic [11:0] col_i = '0, count_i = '0;
   logic busy_o, done_o, err_o, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
   logic [7:0] nand_io_o, nand_io_i, rd_data_o;
   logic nand_io_oe, rd_valid_o, nand_rb_n;

   int nchk = 0, nerr = 0, cyc = 0;
   logic [7:0] cap_b [128];
   logic cap_c [128], cap_a [128];
   int ncap = 0, aidx = 0, conf_seen = 0, conf_done = 0, rd_cnt = 0, rd_base = 0;
   logic [7:0] col_lat = '0;
   logic rb_model = 1'b1, hold_low = 1'b0;
   int busy_left = 0, cur_busy = 10;
   int rr_cnt = 0, rr_first = -1;
   logic rr_arm = 1'b0, in_op = 1'b0;
   int wlow = 0, v3 = 0, v4 = 0, v5 = 0, v7 = 0;
   logic [7:0] w_io = '0;

   assign nand_rb_n = rb_model & ~hold_low;
   assign nand_io_i = (col_lat + 8'(rd_cnt - rd_base)) ^ 8'hA5;

   always #5 clk = ~clk;

   nand_rdseq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i), .page_i(page_i),
      .col_i(col_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_io_o(nand_io_o), .nand_io_oe(nand_io_oe),
      .nand_io_i(nand_io_i), .nand_rb_n(nand_rb_n), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flash side: latch command and address bytes on rising write enable
   always @(posedge nand_we_n) if (rst_n) begin
      if (ncap < 128) begin
         cap_b[ncap] = nand_io_o; cap_c[ncap] = nand_cle; cap_a[ncap] = nand_ale;
         ncap++;
      end
      if (nand_cle) aidx = 0;
      else if (nand_ale) begin
         if (aidx == 0) col_lat = nand_io_o;
         aidx++;
      end
      if (nand_cle && nand_io_o == 8'h30) begin
         conf_seen++;
         rd_base = rd_cnt;
      end
   end

   always @(posedge nand_re_n) if (rst_n) rd_cnt++;

   // busy model and protocol monitors
   always @(negedge clk) begin
      cyc++;
      if (rr_arm) begin
         rr_cnt++;
         if (!nand_re_n) begin rr_first = rr_cnt; rr_arm = 1'b0; end
      end
      if (rst_n) begin
         if (!nand_we_n) begin
            if (wlow == 0) w_io = nand_io_o;
            else if (nand_io_o != w_io) v3++;
            wlow++;
            if (!nand_rb_n) v4++;
            if (!nand_io_oe) v7++;
            in_op = 1'b1;
         end else if (wlow != 0) begin
            if (wlow != T_WP) v3++;
            wlow = 0;
         end
         if (nand_cle && nand_ale) v3++;
         if (!nand_re_n && nand_io_oe) v7++;
         if (done_o || err_o) in_op = 1'b0;
         else if (in_op && nand_ce_n) v5++;
      end
      if (conf_done != conf_seen) begin
         conf_done = conf_seen; rb_model = 1'b0; busy_left = cur_busy;
      end else if (!rb_model) begin
         if (busy_left > 1) busy_left--;
         else begin rb_model = 1'b1; rr_arm = 1'b1; rr_cnt = 0; end
      end
      if (cyc > 100000) begin
         nerr++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   function automatic logic [7:0] exp_addr(input vec_t v, input int i);
      logic [23:0] row;
      row = 24'({v.blk, v.pg});
      case (i)
         0: return v.col[7:0];
         1: return {4'h0, v.col[11:8]};
         2: return row[7:0];
         3: return row[15:8];
         default: return row[23:16];
      endcase
   endfunction

   task automatic issue(input vec_t v);
      block_i = v.blk; page_i = v.pg; col_i = v.col; count_i = v.n;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_op(input vec_t v, input int base);
      int k = 0;
      bit dn = 0, er = 0;
      for (int c = 0; c < 4000 && !dn && !er; c++) begin
         @(negedge clk);
         if (rd_valid_o) begin
            chk(rd_data_o == ((v.col[7:0] + 8'(k)) ^ 8'hA5), "R8 data word", rd_data_o,
                (v.col[7:0] + 8'(k)) ^ 8'hA5);
            k++;
         end
         if (done_o) begin
            dn = 1;
            chk(nand_ce_n == 1'b1, "R9 ce high at done", nand_ce_n, 1);
         end
         if (err_o) er = 1;
      end
      @(negedge clk);
      chk(dn && !er, "R9 completion strobe", {dn, er}, 2'b10);
      chk(!busy_o, "R9 idle after done", busy_o, 0);
      chk(k == int'(v.n), "R8 data cycle count", k, v.n);
      chk(ncap - base == 7, "R11 R2 write cycle count", ncap - base, 7);
      chk(cap_c[base] && !cap_a[base] && cap_b[base] == 8'h00, "R2 setup command",
          cap_b[base], 8'h00);
      for (int i = 0; i < 5; i++)
         chk(cap_a[base+1+i] && !cap_c[base+1+i] && cap_b[base+1+i] == exp_addr(v, i),
             "R2 address byte", cap_b[base+1+i], exp_addr(v, i));
      chk(cap_c[base+6] && cap_b[base+6] == 8'h30, "R2 confirm command", cap_b[base+6], 8'h30);
      if (v.n != 0) chk(rr_first == T_RR + 3, "R6 ready to read gap", rr_first, T_RR + 3);
      chk(v3 == 0, "R3 write pulse timing", v3, 0);
      chk(v4 == 0, "R4 write while busy", v4, 0);
      chk(v5 == 0, "R5 ce held low", v5, 0);
      chk(v7 == 0, "R7 output enable", v7, 0);
   endtask

   initial begin
      int base, c, nv;
      bit er, dn;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R1 strobes idle in reset",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
      chk({nand_cle, nand_ale, nand_io_oe, busy_o} == 4'b0, "R1 latches and oe low in reset",
          {nand_cle, nand_ale, nand_io_oe, busy_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({nand_ce_n, nand_we_n, nand_re_n, busy_o} == 4'b1110, "R1 state after reset",
          {nand_ce_n, nand_we_n, nand_re_n, busy_o}, 4'b1110);

      // table of read operations, each with a stray start mid-way (R11)
      for (int v = 0; v < 5; v++) begin
         cur_busy = int'(VEC[v].bsy);
         base = ncap; rr_first = -1;
         issue(VEC[v]);
         repeat (8) @(negedge clk);
         issue('{11'h000, 6'h00, 12'h000, 12'd2, 16'd0});
         finish_op(VEC[v], base);
      end

      // R10: busy held beyond the timeout
      cur_busy = 6; base = ncap;
      issue('{11'h010, 6'h02, 12'h040, 12'd3, 16'd0});
      for (int i = 0; i < 200 && ncap < base + 7; i++) @(negedge clk);
      hold_low = 1'b1;
      er = 0; dn = 0; nv = 0; c = 0;
      for (int i = 0; i < T_TMO + 100 && !er; i++) begin
         @(negedge clk);
         c++;
         if (rd_valid_o) nv++;
         if (done_o) dn = 1;
         if (err_o) begin
            er = 1;
            chk(nand_ce_n == 1'b1, "R10 ce high at error", nand_ce_n, 1);
         end
      end
      chk(er, "R10 error strobe", er, 1);
      chk(c >= T_TMO && c <= T_TMO + T_WB + 8, "R10 timeout window", c, T_TMO);
      chk(nv == 0 && !dn, "R10 no data or done", nv, 0);
      @(negedge clk);
      chk(!busy_o, "R10 back to idle", busy_o, 0);

      // R4: start while flash still busy waits for ready
      base = ncap; rr_first = -1; cur_busy = 9;
      issue('{11'h003, 6'h04, 12'h0AB, 12'd2, 16'd0});
      repeat (50) @(negedge clk);
      chk(ncap == base, "R4 no write cycle while busy", ncap - base, 0);
      chk(busy_o == 1'b1 && nand_ce_n == 1'b1, "R4 waiting for ready", {busy_o, nand_ce_n}, 2'b11);
      hold_low = 1'b0;
      finish_op('{11'h003, 6'h04, 12'h0AB, 12'd2, 16'd9}, base);

      // R11: quiet after completion
      base = ncap;
      repeat (20) @(negedge clk);
      chk(ncap == base && !busy_o, "R11 no activity without start", ncap - base, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule